// File: doc/BRIEF.md
# Fractional Microsecond Tick Counter

This block keeps a free-running microsecond count from a reference clock whose frequency need not be a whole number of megahertz. A rational scaler, programmed with a dividend and a divisor, turns reference cycles into count enables. It uses an accumulator: every reference cycle the accumulator gains the dividend, and each time it reaches the divisor, the divisor is taken off and the counter steps once. Because the scaler is rational, a 19.2 MHz reference still averages exactly one step per microsecond. An integer divider could not do that.

Software sees two registers. The scaling register holds the divisor in its low byte and the dividend in the next byte, each stored as the value minus one. A read-only register returns the 32-bit count. Register access uses plain single-cycle strobes in the reference clock domain. There is no handshake and no back-pressure: a write takes effect at the edge where it is sampled. Read data is registered and appears one cycle after the read strobe.

Top module: `usec_tick_counter`

## Requirements
- R1: A read at byte offset 0x10 returns the 32-bit count. The count advances by exactly one per scaler tick and wraps modulo 2^32.
- R2: The scaling register sits at byte offset 0x14. Bits [7:0] hold divisor-1 and bits [15:8] hold dividend-1. Reading it returns the written low 16 bits, and bits 31:16 read as zero.
- R3: With dividend D and divisor M (where D <= M), every window of M consecutive reference cycles after a scaling write holds exactly D ticks. Expected results for full windows: 0x000B gives 1 per 12, 0x000C gives 1 per 13, 0x0019 gives 1 per 26, and 0x045F gives 5 per 96.
- R4: A scaling value of 0x0000 (ratio 1/1) makes the count advance on every reference cycle.
- R5: A dividend larger than the divisor saturates the scaler at one tick per reference cycle.
- R6: A write to the scaling register clears the accumulator. No tick occurs in the cycle of the write, and the count keeps its value.
- R7: Writes to offset 0x10 and to unmapped offsets change neither the count nor the scaling register.
- R8: After a synchronous reset, the count, the accumulator, the scaling register and the read data are all zero.
- R9: Read data appears one cycle after the read strobe. It holds the register value at the sampling edge. It is zero for unmapped offsets and in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
A read strobe sampled at edge E returns, one cycle later, the count as it stood before edge E. A tick taken at edge E is therefore first visible to a read sampled at edge E+1.

Rate checks read the count twice with reads exactly N edges apart. The difference between the two reads is the number of ticks in those N cycles, so every expected value is a whole-window count that does not depend on accumulator phase. Checks on scaling writes and ignored writes use back-to-back strobes, so the one suppressed cycle of a scaling write lands on a known edge.

// File: rtl/usec_pkg.sv
package usec_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 32;
  localparam int FRAC_W  = 8;
  localparam int CFG_W   = 2 * FRAC_W;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SCALE = 8'h14;

  typedef struct packed {
    logic [FRAC_W-1:0] num_m1;
    logic [FRAC_W-1:0] den_m1;
  } scale_cfg_t;
endpackage

// File: rtl/usec_frac_tick.sv
module usec_frac_tick #(
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [FRAC_W-1:0] num_m1,
  input  logic [FRAC_W-1:0] den_m1,
  output logic              tick
);
  localparam int ACC_W = FRAC_W + 2;

  logic [ACC_W-1:0] acc, num, den, sum, rem;
  logic             hit;

  always_comb begin
    num  = {2'b00, num_m1} + ACC_W'(1);
    den  = {2'b00, den_m1} + ACC_W'(1);
    sum  = acc + num;
    hit  = (sum >= den);
    rem  = sum - den;
    tick = hit && !clr;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)   acc <= '0;
    else if (hit)     acc <= (rem >= den) ? '0 : rem;
    else              acc <= sum;
  end

  // R5/R3: the remainder never reaches the divisor, so at most one tick per cycle
  a_r5_acc_below_divisor: assert property (@(posedge clk) disable iff (rst)
    acc < den);
  // R4: unit ratio ticks on every cycle that is not a scaling write
  a_r4_unit_ratio_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (num_m1 == '0 && den_m1 == '0 && !clr) |-> tick);
  // R6: a scaling write leaves the accumulator empty
  a_r6_clear_empties_acc: assert property (@(posedge clk) disable iff (rst)
    clr |=> acc == '0);
endmodule

// File: rtl/usec_count.sv
module usec_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (step) count <= count + CNT_W'(1);
  end

  // R1: one step per tick, wrapping modulo 2^CNT_W
  a_r1_step_by_one: assert property (@(posedge clk) disable iff (rst)
    step |=> count == $past(count) + CNT_W'(1));
  a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count));
endmodule

// File: rtl/usec_regs.sv
module usec_regs
  import usec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  output scale_cfg_t        cfg,
  output logic              cfg_wr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_sel;

  assign cfg_wr = wr && (addr == OFS_SCALE);

  always_comb begin
    unique case (addr)
      OFS_COUNT: rd_sel = DATA_W'(count);
      OFS_SCALE: rd_sel = DATA_W'(cfg);
      default:   rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      rdata <= '0;
    end else begin
      if (cfg_wr) cfg <= scale_cfg_t'(wdata[CFG_W-1:0]);
      rdata <= rd ? rd_sel : '0;
    end
  end

  // R7: only the scaling offset can change the scaling register
  a_r7_cfg_only_by_own_write: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(cfg));
  // R9: unmapped reads and idle cycles return zero
  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && addr != OFS_COUNT && addr != OFS_SCALE) |=> rdata == '0);
  a_r9_idle_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata == '0);
endmodule

// File: rtl/usec_tick_counter.sv
module usec_tick_counter
  import usec_pkg::*;
(
  input  logic              ref_clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  scale_cfg_t       cfg;
  logic             cfg_wr;
  logic             tick;
  logic [CNT_W-1:0] count;

  usec_regs u_regs (
    .clk    (ref_clk),
    .rst    (rst),
    .wr     (reg_wr),
    .rd     (reg_rd),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .count  (count),
    .cfg    (cfg),
    .cfg_wr (cfg_wr),
    .rdata  (reg_rdata)
  );

  usec_frac_tick #(.FRAC_W(FRAC_W)) u_tick (
    .clk    (ref_clk),
    .rst    (rst),
    .clr    (cfg_wr),
    .num_m1 (cfg.num_m1),
    .den_m1 (cfg.den_m1),
    .tick   (tick)
  );

  usec_count #(.CNT_W(CNT_W)) u_count (
    .clk   (ref_clk),
    .rst   (rst),
    .step  (tick),
    .count (count)
  );

  // R6: the count does not move across a scaling write
  a_r6_write_cycle_holds_count: assert property (@(posedge ref_clk) disable iff (rst)
    cfg_wr |=> count == $past(count));
  // R8: reset leaves everything at zero
  a_r8_reset_clears: assert property (@(posedge ref_clk)
    rst |=> (count == '0 && cfg == '0 && reg_rdata == '0));
endmodule

// File: tb/test_usec_tick_counter.sv
module test_usec_tick_counter;
  logic        ref_clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int checks = 0;
  int errors = 0;

  always #5 ref_clk = ~ref_clk;

  usec_tick_counter i_usec_tick_counter (
    .ref_clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Called at a negedge; the strobe is sampled at the next posedge.
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge ref_clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge ref_clk);
    reg_wr = 1'b0;
  endtask

  // Ticks across n cycles: two reads whose sampling edges are n apart.
  task automatic window(input int n, output logic [31:0] ticks);
    logic [31:0] a, b;
    rd(8'h10, a);
    repeat (n - 1) @(negedge ref_clk);
    rd(8'h10, b);
    ticks = b - a;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R8 rdata in reset", reg_rdata, 32'h0);
    rst = 1'b0;
    rd(8'h10, d);
    check("R8 count after reset", d, 32'h0);
    rd(8'h14, d);
    check("R8 scale after reset", d, 32'h0);
    check("R9 idle rdata", reg_rdata, 32'h0);
    @(negedge ref_clk);
    check("R9 rdata zero after no read", reg_rdata, 32'h0);
  endtask

  task automatic t_unit_ratio;
    logic [31:0] t;
    window(37, t);
    check("R4 unit ratio 37 cycles", t, 32'd37);
    window(5, t);
    check("R1 unit ratio 5 cycles", t, 32'd5);
  endtask

  task automatic t_scale_keeps_count;
    logic [31:0] a, b;
    rd(8'h10, a);
    wr(8'h14, 32'h0000_000B);
    rd(8'h10, b);
    check("R6 count kept, write cycle silent", b, a + 32'd1);
  endtask

  task automatic t_integer_rates;
    logic [31:0] t, d;
    wr(8'h14, 32'hFFFF_000B);
    rd(8'h14, d);
    check("R2 scale readback masks upper bits", d, 32'h0000_000B);
    window(120, t);
    check("R3 0x000B 120 cycles", t, 32'd10);
    wr(8'h14, 32'h0000_000C);
    window(130, t);
    check("R3 0x000C 130 cycles", t, 32'd10);
    wr(8'h14, 32'h0000_0019);
    window(260, t);
    check("R3 0x0019 260 cycles", t, 32'd10);
  endtask

  task automatic t_fractional;
    logic [31:0] t, d;
    wr(8'h14, 32'h0000_045F);
    rd(8'h14, d);
    check("R2 scale readback 0x045F", d, 32'h0000_045F);
    for (int k = 0; k < 6; k++) begin
      repeat (k * 7) @(negedge ref_clk);
      window(96, t);
      check("R3 0x045F 96-cycle window", t, 32'd5);
    end
    window(960, t);
    check("R3 0x045F 960 cycles", t, 32'd50);
  endtask

  task automatic t_saturate;
    logic [31:0] t;
    wr(8'h14, 32'h0000_0300);
    window(50, t);
    check("R5 dividend above divisor", t, 32'd50);
  endtask

  task automatic t_ignored_writes;
    logic [31:0] a, b, d;
    wr(8'h14, 32'h0000_0000);
    rd(8'h10, a);
    wr(8'h10, 32'h1234_5678);
    wr(8'h20, 32'h0000_0505);
    rd(8'h10, b);
    check("R7 count unaffected by writes", b, a + 32'd3);
    rd(8'h14, d);
    check("R7 scale unaffected by stray write", d, 32'h0);
    rd(8'h20, d);
    check("R9 unmapped read zero", d, 32'h0);
    rd(8'h18, d);
    check("R9 unmapped read 0x18 zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge ref_clk);
    t_reset();
    t_unit_ratio();
    t_scale_keeps_count();
    t_integer_rates();
    t_fractional();
    t_saturate();
    t_ignored_writes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge ref_clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule